// File: doc/BRIEF.md
# Dual-Issue Pairing Check Unit

This block sits at the issue point of a two-pipe in-order core. The two pipes are not equal: the U pipe accepts every instruction class, and the V pipe accepts only a subset. Each cycle the block looks at the two oldest decoded instructions at the head of an instruction queue. It decides whether both can leave together or only the older one. The older instruction always goes to the U pipe. The younger one is placed in the V pipe only when no pairing rule forbids it.

Each queue entry is an 18-bit descriptor. It carries an instruction class, a destination register with a byte-lane mask and a valid flag, and two source registers, each with its own valid flag. The block reports back to the queue, in the same cycle, how many entries it consumed. The chosen slots appear on registered outputs one clock later, together with the number of instructions issued. The execution pipes themselves lie outside the block.

Top module: `pair_issue_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, u_valid, v_valid and issue_cnt are cleared to 0 at that edge.
- R2: pop_cnt is 0 in any cycle where q_valid[0] is 0 (an entry flagged only in q_valid[1] counts as an empty queue) or dn_ready is 0. Nothing issues on the following edge.
- R3: The descriptor fields are: class [17:14], destination register [13:11], destination byte lanes [10:9], destination valid [8], source A [7:5], source A valid [4], source B [3:1], source B valid [0]. When pop_cnt is non-zero, the next edge copies q_desc0 unchanged to u_desc and sets u_valid. When only q_valid[0] is set, pop_cnt is 1 and v_valid stays 0.
- R4: The classes that may go to either pipe are 0 move, 1 address compute, 2 simple ALU, 3 push/pop and 4 test/compare. Two such classes with no register conflict give pop_cnt 2, and the next edge places q_desc1 in v_desc with v_valid set.
- R5: A younger source with its valid bit set that names the older destination (older destination valid set) limits pop_cnt to 1. A matching source number whose valid bit is clear causes no split.
- R6: When both destinations are valid and name the same register, pop_cnt is 1. When either destination valid bit is clear, equal numbers cause no split.
- R7: Writes to the same register split the pair even when the byte-lane masks do not overlap (for example 01 and 10).
- R8: Classes 12 multiply, 13 divide, 14 save-all-registers and 15 block string move never pair, whether older or younger.
- R9: Classes 5 shift, 6 rotate and 7 U-only floating point split the pair when younger. They pair normally when older.
- R10: Classes 8 jump, 9 conditional branch, 10 call and 11 floating-point register swap may pair when younger. An older instruction of one of these classes ends the group, so pop_cnt is 1.
- R11: issue_cnt equals the pop_cnt of the previous cycle, and v_valid is never 1 while u_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | 2 | Bit 0 marks the older queue entry as valid, bit 1 the younger |
| q_desc0 | input | 18 | Older instruction descriptor |
| q_desc1 | input | 18 | Younger instruction descriptor |
| dn_ready | input | 1 | The pipes can accept instructions this cycle |
| pop_cnt | output | 2 | Number of entries consumed from the queue this cycle |
| u_valid | output | 1 | U slot holds an instruction |
| u_desc | output | 18 | Descriptor issued to the U pipe |
| v_valid | output | 1 | V slot holds an instruction |
| v_desc | output | 18 | Descriptor issued to the V pipe |
| issue_cnt | output | 2 | Number of instructions issued this cycle |

## Verification
The check that matters most is what happens when two refusal reasons arrive in the same cycle, or when a legal pair sits next to one that is only almost illegal. Example: a younger source with a number equal to the older destination but its valid flag clear, while the class rules would allow the pair. Directed scenarios build such pairs: the younger class is legal for the V pipe while a register rule fires, or the registers are independent while a class rule fires. Each is judged twice. The same-cycle pop count must be correct, and the slot contents and issue count on the next edge must be correct.

// File: rtl/pair_pkg.sv
// Package: shared widths, the instruction class encoding and the
// descriptor layout for the dual-issue pairing check unit.
// Assumes an 8-entry architectural register file and two byte lanes.
package pair_pkg;
    localparam int REG_W  = 3;
    localparam int LANE_W = 2;
    localparam int CLS_W  = 4;
    localparam int DESC_W = CLS_W + REG_W + LANE_W + 1 + 2 * (REG_W + 1);

    typedef enum logic [CLS_W-1:0] {
        CL_MOVE    = 4'd0,
        CL_ADDR    = 4'd1,
        CL_ALU     = 4'd2,
        CL_STACK   = 4'd3,
        CL_CMP     = 4'd4,
        CL_SHIFT   = 4'd5,
        CL_ROT     = 4'd6,
        CL_FLT_U   = 4'd7,
        CL_JUMP    = 4'd8,
        CL_BRANCH  = 4'd9,
        CL_CALL    = 4'd10,
        CL_FSWAP   = 4'd11,
        CL_MUL     = 4'd12,
        CL_DIV     = 4'd13,
        CL_SAVEALL = 4'd14,
        CL_BLKMOVE = 4'd15
    } cls_t;

    typedef struct packed {
        cls_t              cls;
        logic [REG_W-1:0]  dst;
        logic [LANE_W-1:0] lanes;
        logic              dst_v;
        logic [REG_W-1:0]  src_a;
        logic              src_a_v;
        logic [REG_W-1:0]  src_b;
        logic              src_b_v;
    } desc_t;
endpackage

// File: rtl/pair_class_rule.sv
// Module: class rule for one queue position.
// What it does: reports whether the class at this position forbids a pair.
// Assumes: YOUNG=0 selects the older (U-pipe) position, and YOUNG=1 the
// younger (V-pipe candidate) position.
module pair_class_rule
    import pair_pkg::*;
#(
    parameter bit YOUNG = 1'b0
) (
    input  cls_t cls,
    output logic blocks
);
    if (YOUNG) begin : g_young
        // Younger position: never-pair classes, or classes the V pipe lacks
        always_comb begin
            unique case (cls)
                CL_MOVE, CL_ADDR, CL_ALU, CL_STACK, CL_CMP,
                CL_JUMP, CL_BRANCH, CL_CALL, CL_FSWAP: blocks = 1'b0;
                default:                               blocks = 1'b1;
            endcase
        end
    end else begin : g_old
        // Older position: never-pair classes, or a control transfer ending the group
        always_comb begin
            unique case (cls)
                CL_JUMP, CL_BRANCH, CL_CALL, CL_FSWAP,
                CL_MUL, CL_DIV, CL_SAVEALL, CL_BLKMOVE: blocks = 1'b1;
                default:                                blocks = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pair_dep_check.sv
// Module: register dependence compare between the older and younger entry.
// What it does: flags read-after-write on either younger source and a
// same-register write (any byte lanes) between the two.
// Assumes: comparisons are on architectural register numbers only.
module pair_dep_check #(
    parameter int REG_W = 3,
    parameter int NSRC  = 2
) (
    input  logic [REG_W-1:0]            old_dst,
    input  logic                        old_dst_v,
    input  logic [REG_W-1:0]            yng_dst,
    input  logic                        yng_dst_v,
    input  logic [NSRC-1:0][REG_W-1:0]  yng_src,
    input  logic [NSRC-1:0]             yng_src_v,
    output logic                        raw_hit,
    output logic                        waw_hit
);
    logic [NSRC-1:0] src_hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // Per-source match against the older destination
        assign src_hit[s] = yng_src_v[s] && old_dst_v && (yng_src[s] == old_dst);
    end

    // Any younger source reading the older result
    assign raw_hit = |src_hit;
    // Both write the same register, regardless of byte lanes
    assign waw_hit = old_dst_v && yng_dst_v && (old_dst == yng_dst);
endmodule

// File: rtl/pair_slot_reg.sv
// Module: output slot registers.
// What it does: captures the U and V descriptors and the issue count from
// the cycle's pop decision.
// Assumes: pop_cnt is already 0 whenever the queue head is empty or
// downstream is stalled.
module pair_slot_reg #(
    parameter int DESC_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pop_cnt,
    input  logic [DESC_W-1:0] d_old,
    input  logic [DESC_W-1:0] d_yng,
    output logic              u_valid,
    output logic [DESC_W-1:0] u_desc,
    output logic              v_valid,
    output logic [DESC_W-1:0] v_desc,
    output logic [1:0]        issue_cnt
);
    // Slot capture with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_valid   <= 1'b0;
            v_valid   <= 1'b0;
            u_desc    <= '0;
            v_desc    <= '0;
            issue_cnt <= 2'd0;
        end else begin
            u_valid   <= (pop_cnt != 2'd0);
            v_valid   <= (pop_cnt == 2'd2);
            u_desc    <= (pop_cnt != 2'd0) ? d_old : '0;
            v_desc    <= (pop_cnt == 2'd2) ? d_yng : '0;
            issue_cnt <= pop_cnt;
        end
    end
endmodule

// File: rtl/pair_issue_top.sv
// Module: dual-issue pairing check unit (top).
// What it does: decides each cycle whether the two oldest queue entries
// issue together (older to U, younger to V) or the older issues alone,
// returns the pop count to the queue, and registers the issued slots.
// Assumes: the queue presents entries in program order in q_desc0/q_desc1.
module pair_issue_top
    import pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        q_valid,
    input  logic [DESC_W-1:0] q_desc0,
    input  logic [DESC_W-1:0] q_desc1,
    input  logic              dn_ready,
    output logic [1:0]        pop_cnt,
    output logic              u_valid,
    output logic [DESC_W-1:0] u_desc,
    output logic              v_valid,
    output logic [DESC_W-1:0] v_desc,
    output logic [1:0]        issue_cnt
);
    desc_t     dsc [2];
    logic [1:0] cls_block;
    logic      raw_hit;
    logic      waw_hit;
    logic      can_issue;
    logic      can_pair;

    assign dsc[0] = desc_t'(q_desc0);
    assign dsc[1] = desc_t'(q_desc1);

    for (genvar p = 0; p < 2; p++) begin : g_rule
        pair_class_rule #(.YOUNG(p == 1)) u_rule (
            .cls    (dsc[p].cls),
            .blocks (cls_block[p])
        );
    end

    pair_dep_check #(.REG_W(REG_W), .NSRC(2)) u_dep (
        .old_dst   (dsc[0].dst),
        .old_dst_v (dsc[0].dst_v),
        .yng_dst   (dsc[1].dst),
        .yng_dst_v (dsc[1].dst_v),
        .yng_src   ({dsc[1].src_b, dsc[1].src_a}),
        .yng_src_v ({dsc[1].src_b_v, dsc[1].src_a_v}),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit)
    );

    // Issue and pairing decision for this cycle
    always_comb begin
        can_issue = q_valid[0] && dn_ready;
        can_pair  = can_issue && q_valid[1] && !(|cls_block) && !raw_hit && !waw_hit;
        if (!can_issue)    pop_cnt = 2'd0;
        else if (can_pair) pop_cnt = 2'd2;
        else               pop_cnt = 2'd1;
    end

    pair_slot_reg #(.DESC_W(DESC_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_cnt   (pop_cnt),
        .d_old     (q_desc0),
        .d_yng     (q_desc1),
        .u_valid   (u_valid),
        .u_desc    (u_desc),
        .v_valid   (v_valid),
        .v_desc    (v_desc),
        .issue_cnt (issue_cnt)
    );
endmodule

// File: rtl/pair_issue_chk.sv
// Module: assertion checker for pair_issue_top, attached by bind.
// What it does: checks the pop/issue relations and the pairing refusals
// at the ports of the top module.
module pair_issue_chk
    import pair_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        q_valid,
    input logic [DESC_W-1:0] q_desc0,
    input logic [DESC_W-1:0] q_desc1,
    input logic              dn_ready,
    input logic [1:0]        pop_cnt,
    input logic              u_valid,
    input logic [DESC_W-1:0] u_desc,
    input logic              v_valid,
    input logic [1:0]        issue_cnt
);
    desc_t o_d;
    desc_t y_d;
    assign o_d = desc_t'(q_desc0);
    assign y_d = desc_t'(q_desc1);

    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_valid[0] || !dn_ready) |-> (pop_cnt == 2'd0)); // R2
    AST_U_TAKES_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt != 2'd0) |=> (u_valid && u_desc == $past(q_desc0))); // R3
    AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !(o_d.dst_v && ((y_d.src_a_v && y_d.src_a == o_d.dst) || (y_d.src_b_v && y_d.src_b == o_d.dst)))); // R5
    AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> !(o_d.dst_v && y_d.dst_v && o_d.dst == y_d.dst)); // R6
    AST_NEVER_PAIR_CLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> (o_d.cls < CL_MUL && y_d.cls < CL_MUL)); // R8
    AST_CTRL_ENDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cnt == 2'd2) |-> (o_d.cls < CL_JUMP)); // R10
    AST_ISSUE_FOLLOWS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (issue_cnt == $past(pop_cnt))); // R11
    AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |-> u_valid); // R11
endmodule

bind pair_issue_top pair_issue_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_valid   (q_valid),
    .q_desc0   (q_desc0),
    .q_desc1   (q_desc1),
    .dn_ready  (dn_ready),
    .pop_cnt   (pop_cnt),
    .u_valid   (u_valid),
    .u_desc    (u_desc),
    .v_valid   (v_valid),
    .issue_cnt (issue_cnt)
);

// File: tb/sim_pair_issue_top.sv
// Bench: directed scenarios for pair_issue_top, one task per scenario.
module sim_pair_issue_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  q_valid = 2'b00;
    logic [17:0] q_desc0 = '0;
    logic [17:0] q_desc1 = '0;
    logic        dn_ready = 1'b0;
    logic [1:0]  pop_cnt;
    logic        u_valid;
    logic [17:0] u_desc;
    logic        v_valid;
    logic [17:0] v_desc;
    logic [1:0]  issue_cnt;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pair_issue_top u0 (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_desc0(q_desc0),
        .q_desc1(q_desc1), .dn_ready(dn_ready), .pop_cnt(pop_cnt),
        .u_valid(u_valid), .u_desc(u_desc), .v_valid(v_valid),
        .v_desc(v_desc), .issue_cnt(issue_cnt)
    );

    // Descriptor builder using the field positions stated in R3
    function automatic logic [17:0] mk(int cls, int dst, int lanes, bit dv,
                                       int sa, bit sav, int sb, bit sbv);
        return {4'(cls), 3'(dst), 2'(lanes), dv, 3'(sa), sav, 3'(sb), sbv};
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply a pair, check the same-cycle pop count, then the registered slots
    task automatic run_pair(string req, logic [1:0] qv, logic [17:0] d0,
                            logic [17:0] d1, bit rdy, int exp_pop);
        @(negedge clk);
        q_valid = qv; q_desc0 = d0; q_desc1 = d1; dn_ready = rdy;
        #1;
        check({req, " pop_cnt"}, int'(pop_cnt), exp_pop);
        @(posedge clk);
        #2;
        check({req, " R11 issue_cnt"}, int'(issue_cnt), exp_pop);
        check({req, " u_valid"}, int'(u_valid), int'(exp_pop != 0));
        check({req, " v_valid"}, int'(v_valid), int'(exp_pop == 2));
        if (exp_pop != 0) check({req, " R3 u_desc"}, int'(u_desc), int'(d0));
        if (exp_pop == 2) check({req, " R4 v_desc"}, int'(v_desc), int'(d1));
        @(negedge clk);
        q_valid = 2'b00; dn_ready = 1'b0;
    endtask

    task automatic t_reset_r1();
        @(posedge clk); #2;
        check("R1 u_valid", int'(u_valid), 0);
        check("R1 v_valid", int'(v_valid), 0);
        check("R1 issue_cnt", int'(issue_cnt), 0);
    endtask

    task automatic t_idle_r2();
        run_pair("R2 empty", 2'b00, mk(0,1,3,1,2,1,3,1), mk(2,4,3,1,5,1,6,1), 1, 0);
        run_pair("R2 young-only", 2'b10, mk(0,1,3,1,2,1,3,1), mk(2,4,3,1,5,1,6,1), 1, 0);
        run_pair("R2 not-ready", 2'b11, mk(0,1,3,1,2,1,3,1), mk(2,4,3,1,5,1,6,1), 0, 0);
    endtask

    task automatic t_single_r3();
        run_pair("R3 single", 2'b01, mk(2,5,3,1,6,1,7,0), mk(0,1,3,1,2,1,3,1), 1, 1);
    endtask

    task automatic t_pair_r4();
        run_pair("R4 move+alu", 2'b11, mk(0,1,3,1,2,1,0,0), mk(2,3,3,1,4,1,5,1), 1, 2);
        run_pair("R4 addr+cmp", 2'b11, mk(1,6,3,1,7,1,0,0), mk(4,0,0,0,2,1,3,1), 1, 2);
        run_pair("R4 stack+stack", 2'b11, mk(3,4,3,1,5,1,0,0), mk(3,2,3,1,6,1,0,0), 1, 2);
    endtask

    task automatic t_raw_r5();
        run_pair("R5 raw srcB", 2'b11, mk(2,1,3,1,2,1,3,1), mk(2,4,3,1,5,1,1,1), 1, 1);
        run_pair("R5 raw srcA", 2'b11, mk(0,7,3,1,2,1,0,0), mk(4,0,0,0,7,1,3,1), 1, 1);
        run_pair("R5 unused src", 2'b11, mk(2,1,3,1,2,1,3,1), mk(2,4,3,1,1,0,1,0), 1, 2);
    endtask

    task automatic t_waw_r6();
        run_pair("R6 waw", 2'b11, mk(0,2,3,1,5,1,0,0), mk(2,2,3,1,6,1,7,1), 1, 1);
        run_pair("R6 no old dst", 2'b11, mk(4,2,3,0,5,1,6,1), mk(2,2,3,1,6,1,7,1), 1, 2);
    endtask

    task automatic t_partial_r7();
        run_pair("R7 lo/hi lanes", 2'b11, mk(0,3,1,1,5,1,0,0), mk(0,3,2,1,6,1,0,0), 1, 1);
    endtask

    task automatic t_never_r8();
        run_pair("R8 mul older", 2'b11, mk(12,1,3,1,2,1,3,1), mk(0,4,3,1,5,1,0,0), 1, 1);
        run_pair("R8 div younger", 2'b11, mk(0,1,3,1,2,1,0,0), mk(13,4,3,1,5,1,6,1), 1, 1);
        run_pair("R8 saveall younger", 2'b11, mk(2,1,3,1,2,1,0,0), mk(14,0,0,0,0,0,0,0), 1, 1);
        run_pair("R8 blkmove older", 2'b11, mk(15,0,0,0,0,0,0,0), mk(2,4,3,1,5,1,6,1), 1, 1);
    endtask

    task automatic t_uonly_r9();
        run_pair("R9 shift younger", 2'b11, mk(0,1,3,1,2,1,0,0), mk(5,4,3,1,5,1,0,0), 1, 1);
        run_pair("R9 fltU younger", 2'b11, mk(0,1,3,1,2,1,0,0), mk(7,4,3,1,5,1,0,0), 1, 1);
        run_pair("R9 rotate older", 2'b11, mk(6,1,3,1,1,1,0,0), mk(0,4,3,1,5,1,0,0), 1, 2);
    endtask

    task automatic t_ctrl_r10();
        run_pair("R10 branch younger", 2'b11, mk(4,0,0,0,2,1,3,1), mk(9,0,0,0,0,0,0,0), 1, 2);
        run_pair("R10 fswap younger", 2'b11, mk(2,1,3,1,2,1,0,0), mk(11,0,0,0,0,0,0,0), 1, 2);
        run_pair("R10 jump older", 2'b11, mk(8,0,0,0,0,0,0,0), mk(0,4,3,1,5,1,0,0), 1, 1);
        run_pair("R10 call older", 2'b11, mk(10,0,0,0,0,0,0,0), mk(9,0,0,0,0,0,0,0), 1, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_r1();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle_r2();
        t_single_r3();
        t_pair_r4();
        t_raw_r5();
        t_waw_r6();
        t_partial_r7();
        t_never_r8();
        t_uonly_r9();
        t_ctrl_r10();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule